// File: doc/BRIEF.md
# Reference Impairment Monitor with Automatic Holdover

This block watches the timing reference that drives a digital PLL. It samples the reference in the local clock domain and counts its rising edges over fixed gate windows. It raises an impairment flag when the reference goes silent, when the count for a window falls outside a programmable band, or when the count jumps too far from the previous window. While the flag is up, the loop is told to enter holdover.

In normal operation the block copies the loop's frequency control word into a two-entry history at a fixed interval. When a fault begins, it freezes the older of the two entries as the holdover word. That word therefore describes the loop as it was one to two intervals before the fault, which keeps a fault's early disturbance out of the held value. Recovery needs a programmable run of consecutive good windows. A recovery also discards the history, so a new holdover word is only trusted after two fresh snapshots.

Top module: `ref_holdover_mon`

## Requirements
- R1: After reset, impaired_o, holdover_o and hist_full_o are all low.
- R2: If no rising edge of ref_i is seen for los_lim_i local cycles, impaired_o goes high on the next cycle and stays high while the silence lasts.
- R3: A gate window of GATE_CYC cycles whose edge count is below lo_lim_i or above hi_lim_i sets impaired_o.
- R4: A gate window whose edge count differs from the previous window's count by more than step_lim_i sets impaired_o, even if both counts lie inside the band.
- R5: impaired_o clears only at the end of a good window that completes good_need_i consecutive good windows with no loss of signal between them (a value of 0 acts as 1).
- R6: While not impaired, fcw_i is captured every SNAP_CYC cycles into alternating entries, and hist_full_o goes high once two captures exist.
- R7: On the rising edge of impaired_o, hold_fcw_o takes the older history entry. That entry was captured between SNAP_CYC and 2*SNAP_CYC cycles earlier. hold_fcw_o then stays constant while impaired_o is high.
- R8: holdover_o is high only while impaired_o is high and the history was full when the fault began. A fault that starts with a partial history raises impaired_o only.
- R9: When impaired_o falls, the history is discarded: hist_full_o is low on the next cycle and stays low until two new captures.
- R10: holdover_o is never high while impaired_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_i | input | 1 | Timing reference, asynchronous to clk_i |
| fcw_i | input | FCW_W | Live loop frequency control word |
| lo_lim_i | input | CNT_W | Lowest acceptable edge count per window |
| hi_lim_i | input | CNT_W | Highest acceptable edge count per window |
| step_lim_i | input | CNT_W | Largest allowed count change between adjacent windows |
| los_lim_i | input | LOS_W | Silent cycles that declare loss of signal |
| good_need_i | input | RUN_W | Consecutive good windows needed to recover |
| impaired_o | output | 1 | Reference impairment flag |
| holdover_o | output | 1 | Automatic holdover request to the loop |
| hold_fcw_o | output | FCW_W | Frozen holdover control word |
| hist_full_o | output | 1 | Two valid snapshots are held |

## Verification
Two things are hard to reach from the ports. The first is the age of the frozen word: the bench drives fcw_i with a running cycle stamp, so the held value shows when it was captured, and it compares that stamp with the cycle at which the fault began. The second is a jump that stays inside the count band. The bench steps the reference period from one in-band rate to another. Because the partial window at the change cannot be close to both rates, one of the next two windows must breach the step limit, and the bench checks that a fault appeared somewhere in that span rather than at one exact cycle. The bench also starts a fault right after a recovery, while the history is still partial, to show that the flag rises without a holdover request.

// File: rtl/ref_hold_pkg.sv
package ref_hold_pkg;
  typedef enum logic {
    ST_LOCK = 1'b0,
    ST_HOLD = 1'b1
  } mon_state_e;

  typedef struct packed {
    logic done;
    logic good;
  } win_res_t;
endpackage

// File: rtl/rhm_edge_sync.sv
module rhm_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic edge_o
);
  logic [SYNC_STAGES:0] sh_q;

  genvar g;
  generate
    for (g = 0; g <= SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sh_q[0] <= 1'b0;
          else         sh_q[0] <= ref_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sh_q[g] <= 1'b0;
          else         sh_q[g] <= sh_q[g-1];
        end
      end
    end
  endgenerate

  assign edge_o = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
endmodule

// File: rtl/rhm_freq_meter.sv
module rhm_freq_meter
  import ref_hold_pkg::*;
#(
  parameter int GATE_CYC = 1024,
  parameter int LOS_W    = 16,
  localparam int GATE_W  = $clog2(GATE_CYC),
  localparam int CNT_W   = $clog2(GATE_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             edge_i,
  input  logic [CNT_W-1:0] lo_lim_i,
  input  logic [CNT_W-1:0] hi_lim_i,
  input  logic [CNT_W-1:0] step_lim_i,
  input  logic [LOS_W-1:0] los_lim_i,
  output win_res_t         win_o,
  output logic             los_o
);
  logic [GATE_W-1:0] gate_q;
  logic [CNT_W-1:0]  edge_cnt_q, prev_q, cnt_now, diff;
  logic              prev_ok_q, gate_end, in_band, step_ok;
  logic [LOS_W-1:0]  los_cnt_q;
  win_res_t          win_q;

  assign gate_end = (gate_q == GATE_W'(GATE_CYC - 1));
  assign cnt_now  = edge_cnt_q + CNT_W'(edge_i);
  assign diff     = (cnt_now >= prev_q) ? (cnt_now - prev_q) : (prev_q - cnt_now);
  assign in_band  = (cnt_now >= lo_lim_i) && (cnt_now <= hi_lim_i);
  assign step_ok  = !prev_ok_q || (diff <= step_lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q     <= '0;
      edge_cnt_q <= '0;
      prev_q     <= '0;
      prev_ok_q  <= 1'b0;
      win_q      <= '0;
    end else begin
      win_q.done <= gate_end;
      if (gate_end) begin
        gate_q     <= '0;
        edge_cnt_q <= '0;
        prev_q     <= cnt_now;
        prev_ok_q  <= 1'b1;
        win_q.good <= in_band && step_ok;
      end else begin
        gate_q     <= gate_q + 1'b1;
        edge_cnt_q <= cnt_now;
      end
    end
  end

  // silence counter, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         los_cnt_q <= '0;
    else if (edge_i)     los_cnt_q <= '0;
    else if (!(&los_cnt_q)) los_cnt_q <= los_cnt_q + 1'b1;
  end

  assign los_o = (los_cnt_q >= los_lim_i);
  assign win_o = win_q;

  // R3
  win_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_q.done |=> !win_q.done);

  // R2
  los_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && !(&los_cnt_q)) |=> (los_cnt_q == '0));
endmodule

// File: rtl/rhm_impair_fsm.sv
module rhm_impair_fsm
  import ref_hold_pkg::*;
#(
  parameter int RUN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  win_res_t         win_i,
  input  logic             los_i,
  input  logic [RUN_W-1:0] good_need_i,
  output logic             impaired_o
);
  mon_state_e       state_q;
  logic [RUN_W-1:0] run_q, need_eff;
  logic [RUN_W:0]   run_nxt;

  assign need_eff = (good_need_i == '0) ? RUN_W'(1) : good_need_i;
  assign run_nxt  = {1'b0, run_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LOCK;
      run_q   <= '0;
    end else if (los_i || (win_i.done && !win_i.good)) begin
      state_q <= ST_HOLD;
      run_q   <= '0;
    end else if (win_i.done && state_q == ST_HOLD) begin
      if (run_nxt >= {1'b0, need_eff}) begin
        state_q <= ST_LOCK;
        run_q   <= '0;
      end else begin
        run_q   <= run_nxt[RUN_W-1:0];
      end
    end
  end

  assign impaired_o = (state_q == ST_HOLD);

  // R2
  los_trip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    los_i |=> impaired_o);

  // R3
  bad_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_i.done && !win_i.good) |=> impaired_o);

  // R5
  release_at_good_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(impaired_o) |-> $past(win_i.done && win_i.good && !los_i));
endmodule

// File: rtl/rhm_hold_hist.sv
module rhm_hold_hist #(
  parameter int FCW_W    = 32,
  parameter int SNAP_CYC = 3_000_000,
  localparam int SNAP_W  = $clog2(SNAP_CYC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [FCW_W-1:0] fcw_i,
  input  logic             impaired_i,
  output logic [FCW_W-1:0] hold_fcw_o,
  output logic             hold_ok_o,
  output logic             hist_full_o
);
  logic [FCW_W-1:0]  ent_q [2];
  logic              wr_ptr_q, imp_d_q, hold_ok_q;
  logic [1:0]        n_snap_q;
  logic [SNAP_W-1:0] timer_q;
  logic [FCW_W-1:0]  hold_q;
  logic              snap_tick;

  assign snap_tick = (timer_q == SNAP_W'(SNAP_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_q[0]  <= '0;
      ent_q[1]  <= '0;
      wr_ptr_q  <= 1'b0;
      n_snap_q  <= '0;
      timer_q   <= '0;
      imp_d_q   <= 1'b0;
      hold_q    <= '0;
      hold_ok_q <= 1'b0;
    end else begin
      imp_d_q <= impaired_i;
      if (impaired_i) begin
        timer_q <= '0;
        if (!imp_d_q) begin
          // entry at wr_ptr is the older one (next to be overwritten)
          hold_q    <= ent_q[wr_ptr_q];
          hold_ok_q <= (n_snap_q == 2'd2);
        end
      end else if (imp_d_q) begin
        n_snap_q  <= '0;
        hold_ok_q <= 1'b0;
        timer_q   <= '0;
      end else if (snap_tick) begin
        timer_q         <= '0;
        ent_q[wr_ptr_q] <= fcw_i;
        wr_ptr_q        <= ~wr_ptr_q;
        if (n_snap_q != 2'd2) n_snap_q <= n_snap_q + 1'b1;
      end else begin
        timer_q <= timer_q + 1'b1;
      end
    end
  end

  assign hold_fcw_o  = hold_q;
  assign hold_ok_o   = hold_ok_q;
  assign hist_full_o = (n_snap_q == 2'd2);

  // R7
  hold_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (impaired_i && imp_d_q) |=> $stable(hold_q));

  // R6
  snap_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_snap_q != 2'd3);

  // R6
  no_snap_in_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (impaired_i && imp_d_q) |=> $stable(n_snap_q));
endmodule

// File: rtl/ref_holdover_mon.sv
module ref_holdover_mon
  import ref_hold_pkg::*;
#(
  parameter int FCW_W       = 32,
  parameter int GATE_CYC    = 1024,
  parameter int SNAP_CYC    = 3_000_000,
  parameter int LOS_W       = 16,
  parameter int RUN_W       = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(GATE_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_i,
  input  logic [FCW_W-1:0] fcw_i,
  input  logic [CNT_W-1:0] lo_lim_i,
  input  logic [CNT_W-1:0] hi_lim_i,
  input  logic [CNT_W-1:0] step_lim_i,
  input  logic [LOS_W-1:0] los_lim_i,
  input  logic [RUN_W-1:0] good_need_i,
  output logic             impaired_o,
  output logic             holdover_o,
  output logic [FCW_W-1:0] hold_fcw_o,
  output logic             hist_full_o
);
  logic     ref_edge, los, hold_ok;
  win_res_t win;

  rhm_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ref_i  (ref_i),
    .edge_o (ref_edge)
  );

  rhm_freq_meter #(.GATE_CYC(GATE_CYC), .LOS_W(LOS_W)) i_meter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .edge_i     (ref_edge),
    .lo_lim_i   (lo_lim_i),
    .hi_lim_i   (hi_lim_i),
    .step_lim_i (step_lim_i),
    .los_lim_i  (los_lim_i),
    .win_o      (win),
    .los_o      (los)
  );

  rhm_impair_fsm #(.RUN_W(RUN_W)) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .win_i       (win),
    .los_i       (los),
    .good_need_i (good_need_i),
    .impaired_o  (impaired_o)
  );

  rhm_hold_hist #(.FCW_W(FCW_W), .SNAP_CYC(SNAP_CYC)) i_hist (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fcw_i       (fcw_i),
    .impaired_i  (impaired_o),
    .hold_fcw_o  (hold_fcw_o),
    .hold_ok_o   (hold_ok),
    .hist_full_o (hist_full_o)
  );

  assign holdover_o = impaired_o & hold_ok;

  // R10
  hov_needs_imp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    holdover_o |-> impaired_o);

  // R9
  hist_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(impaired_o) |=> !hist_full_o);

  // R8
  hov_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(impaired_o) |=> (holdover_o == $past(hist_full_o)));
endmodule

// File: tb/test_ref_holdover_mon.sv
module test_ref_holdover_mon;
  localparam int FCW_W = 32;
  localparam int GATE  = 64;
  localparam int SNAP  = 300;
  localparam int LOSW  = 8;
  localparam int RUNW  = 4;
  localparam int CNTW  = $clog2(GATE + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_r = 1'b0;
  bit   ref_on = 1'b0;
  int   ref_half = 20;
  int unsigned cyc = 0;

  logic [CNTW-1:0] lo_lim = 7'd12, hi_lim = 7'd24, step_lim = 7'd2;
  logic [LOSW-1:0] los_lim = 8'd20;
  logic [RUNW-1:0] good_need = 4'd3;
  logic impaired, holdover, hist_full;
  logic [FCW_W-1:0] hold_fcw, fcw;

  int n_run = 0, n_fail = 0, rise_n = 0;
  int unsigned rise_cyc = 0;
  logic imp_prev = 1'b0;
  bit   done = 1'b0;

  string      tag_q[$];
  logic [2:0] exp_q[$];

  always #5 clk = ~clk;
  always_ff @(posedge clk) cyc <= cyc + 1;
  assign fcw = cyc;  // time stamp as control word

  always begin
    if (ref_on) begin
      #(ref_half);
      ref_r = ~ref_r;
    end else begin
      ref_r = 1'b0;
      #5;
    end
  end

  ref_holdover_mon #(
    .FCW_W(FCW_W), .GATE_CYC(GATE), .SNAP_CYC(SNAP), .LOS_W(LOSW), .RUN_W(RUNW)
  ) i_ref_holdover_mon (
    .clk_i(clk), .rst_ni(rst_n), .ref_i(ref_r), .fcw_i(fcw),
    .lo_lim_i(lo_lim), .hi_lim_i(hi_lim), .step_lim_i(step_lim),
    .los_lim_i(los_lim), .good_need_i(good_need),
    .impaired_o(impaired), .holdover_o(holdover),
    .hold_fcw_o(hold_fcw), .hist_full_o(hist_full)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scoreboard driver side
  task automatic expect_st(string req, logic imp, logic hov, logic full);
    tag_q.push_back(req);
    exp_q.push_back({imp, hov, full});
    while (exp_q.size() != 0) @(posedge clk);
  endtask

  // scoreboard monitor side
  always @(negedge clk) begin
    if (exp_q.size() != 0) begin
      automatic logic [2:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk(t, "impaired_o", int'(impaired), int'(e[2]));
      chk(t, "holdover_o", int'(holdover), int'(e[1]));
      chk(t, "hist_full_o", int'(hist_full), int'(e[0]));
    end
  end

  always @(negedge clk) begin
    if (impaired && !imp_prev) begin
      rise_cyc = cyc;
      rise_n++;
    end
    imp_prev = impaired;
  end

  task automatic chk_age(string req);
    automatic int age = int'(rise_cyc) - int'(hold_fcw);
    n_run++;
    if (age < SNAP - 3 || age > 2 * SNAP + 3) begin
      n_fail++;
      $display("FAIL %s hold word age: actual %0d expected %0d..%0d", req, age, SNAP, 2 * SNAP);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    automatic int r0;
    automatic logic [FCW_W-1:0] held;
    repeat (3) @(posedge clk);
    expect_st("R1", 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    ref_half = 20;
    ref_on = 1'b1;

    // R6: steady reference, two snapshots taken
    repeat (700) @(posedge clk);
    expect_st("R6", 1'b0, 1'b0, 1'b1);

    // R2: reference lost
    ref_on = 1'b0;
    repeat (200) @(posedge clk);
    expect_st("R2", 1'b1, 1'b1, 1'b1);
    chk_age("R7");
    held = hold_fcw;

    // R5: recovery needs several good windows
    ref_on = 1'b1;
    repeat (150) @(posedge clk);
    expect_st("R5", 1'b1, 1'b1, 1'b1);
    chk("R7", "hold_fcw_o stable", int'(hold_fcw), int'(held));
    repeat (350) @(posedge clk);
    expect_st("R9", 1'b0, 1'b0, 1'b0);

    // R3: frequency above band
    repeat (700) @(posedge clk);
    expect_st("R6", 1'b0, 1'b0, 1'b1);
    ref_half = 12;
    repeat (150) @(posedge clk);
    expect_st("R3", 1'b1, 1'b1, 1'b1);
    chk_age("R7");

    // R8: fault with partial history gives no holdover request
    ref_half = 20;
    repeat (450) @(posedge clk);
    expect_st("R9", 1'b0, 1'b0, 1'b0);
    ref_half = 30;
    repeat (150) @(posedge clk);
    expect_st("R8", 1'b1, 1'b0, 1'b0);
    chk("R10", "holdover_o while partial", int'(holdover), 0);

    // R4: in-band jump
    ref_half = 20;
    repeat (1100) @(posedge clk);
    expect_st("R6", 1'b0, 1'b0, 1'b1);
    r0 = rise_n;
    ref_half = 14;
    repeat (250) @(posedge clk);
    chk("R4", "fault seen after jump", int'(rise_n > r0), 1);
    repeat (450) @(posedge clk);
    expect_st("R5", 1'b0, 1'b0, 1'b0);

    finish_run();
  end
endmodule